// File: doc/BRIEF.md
# Indirect Stream Address Generator

This block produces the address sequence for a register-mapped operand stream that feeds a floating-point datapath. In strided mode it emits `base + k*stride` for a programmed number of elements, so software written for a plain strided generator runs unchanged. In indirect mode it reads packed 64-bit index words over its own read-only index port. It splits each word into 16-bit or 32-bit indices and scales each index to a byte offset for 64-bit elements, with an optional extra left shift for walking a strided dense axis. It then adds the base address.

The data-side requester takes addresses over a valid/ready handshake. Index words are prefetched into a small buffer, so one address can leave per cycle while the index port keeps up. Software programs five registers through a write strobe. Any write aborts the running stream. A write to the control register launches a new stream one cycle later. Index words still in flight from an aborted stream are discarded.

Top module: `idx_stream_agen`

## Requirements
- R1: Strided mode (control bit 0 clear): the k-th address, k = 0 .. count-1, is `base + k*stride`. No index request is issued in this mode.
- R2: Indirect mode with 16-bit indices (control bit 1 clear): each 64-bit word holds four indices, taken from bits [15:0] upward. The address is `base + (index << 3)`. The indices {2,3,0,2,3,4,2} give base+16, +24, +0, +16, +24, +32, +16.
- R3: Indirect mode with 32-bit indices (control bit 1 set): each word holds two indices, bits [31:0] first.
- R4: Control bits [6:4] add an extra shift s, giving the address `base + (index << (3+s))`.
- R5: The index pointer may point into the middle of a word. The first index is the lane at byte offset `ptr[2:0]`. Index words are requested at `ptr` rounded down to 8, then at consecutive 8-byte steps, and only as many words as the count needs. Surplus indices in the last word are dropped.
- R6: With a one-cycle index memory and the address output always ready, addresses leave on consecutive cycles after the first, for both index widths.
- R7: While `addr_ready_i` is low, `addr_valid_o` and `addr_o` hold steady, and no index is lost or repeated.
- R8: `done_o` rises the cycle after the last address is accepted, with `addr_valid_o` low. A count of zero reaches done without emitting any address.
- R9: A configuration write aborts the current stream. A control write starts a new stream from the new settings, and index responses still outstanding from the old stream are discarded.
- R10: An index request stays valid with a stable address until it is accepted. Buffered plus outstanding words never exceed the buffer depth.
- R11: After reset, `addr_valid_o`, `done_o` and `idx_req_valid_o` are low.
- Register map on `cfg_addr_i`: 0 base, 1 stride, 2 index pointer, 3 count, 4 control.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 3 | Register select |
| cfg_wdata_i | input | AW | Register write data |
| idx_req_valid_o | output | 1 | Index word request valid |
| idx_req_ready_i | input | 1 | Index port accepts request |
| idx_req_addr_o | output | AW | Byte address of index word (8-aligned) |
| idx_rsp_valid_i | input | 1 | Index word returned |
| idx_rsp_data_i | input | 64 | Index word data |
| addr_valid_o | output | 1 | Stream address valid |
| addr_ready_i | input | 1 | Requester takes the address |
| addr_o | output | AW | Stream address |
| done_o | output | 1 | All addresses of the stream accepted |

## Verification
The bench uses the default parameters: 32-bit addresses, 16-bit count, a 3-bit extra shift and a two-word prefetch buffer. With a depth of two, the credit limit and the push-while-pop case are hit within a few words. Streams of two to seven indices then cover the mid-word starts, the dropped tails and the consecutive-cycle throughput. The index memory model has an adjustable latency. A long latency leaves a word in flight across a full reprogramming sequence, which exercises the discard path.

// File: rtl/isag_pkg.sv
package isag_pkg;
  localparam int unsigned WORD_W = 64;
  localparam int unsigned WORD_BYTES = WORD_W / 8;
  localparam int unsigned LANES16 = WORD_W / 16;

  localparam logic [2:0] REG_BASE   = 3'd0;
  localparam logic [2:0] REG_STRIDE = 3'd1;
  localparam logic [2:0] REG_IPTR   = 3'd2;
  localparam logic [2:0] REG_COUNT  = 3'd3;
  localparam logic [2:0] REG_CTRL   = 3'd4;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DONE} state_e;
endpackage

// File: rtl/isag_cfg_regs.sv
module isag_cfg_regs import isag_pkg::*; #(
  parameter int unsigned AW = 32,
  parameter int unsigned CW = 16,
  parameter int unsigned SW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [2:0]    addr_i,
  input  logic [AW-1:0] wdata_i,
  output logic [AW-1:0] base_o,
  output logic [AW-1:0] stride_o,
  output logic [AW-1:1] iptr_o,
  output logic [CW-1:0] count_o,
  output logic          indirect_o,
  output logic          wide_o,
  output logic [SW-1:0] shift_o,
  output logic          start_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_o     <= '0;
      stride_o   <= '0;
      iptr_o     <= '0;
      count_o    <= '0;
      indirect_o <= 1'b0;
      wide_o     <= 1'b0;
      shift_o    <= '0;
      start_o    <= 1'b0;
    end else begin
      // launch one cycle after the control write, when all fields are settled
      start_o <= we_i && (addr_i == REG_CTRL);
      if (we_i) begin
        unique case (addr_i)
          REG_BASE:   base_o   <= wdata_i;
          REG_STRIDE: stride_o <= wdata_i;
          REG_IPTR:   iptr_o   <= wdata_i[AW-1:1];
          REG_COUNT:  count_o  <= wdata_i[CW-1:0];
          REG_CTRL: begin
            indirect_o <= wdata_i[0];
            wide_o     <= wdata_i[1];
            shift_o    <= wdata_i[4 +: SW];
          end
          default: ;
        endcase
      end
    end
  end

  AST_START_FROM_CTRL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(start_o) |-> $past(we_i && addr_i == REG_CTRL)); // R9
endmodule

// File: rtl/isag_idx_fetch.sv
module isag_idx_fetch import isag_pkg::*; #(
  parameter int unsigned AW    = 32,
  parameter int unsigned CW    = 16,
  parameter int unsigned DEPTH = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              abort_i,
  input  logic              indirect_i,
  input  logic              wide_i,
  input  logic [1:0]        start_lane_i,
  input  logic [AW-1:3]     word_ptr_i,
  input  logic [CW-1:0]     count_i,
  output logic              req_valid_o,
  input  logic              req_ready_i,
  output logic [AW-1:0]     req_addr_o,
  input  logic              rsp_valid_i,
  input  logic [WORD_W-1:0] rsp_data_i,
  output logic              head_valid_o,
  output logic [WORD_W-1:0] head_o,
  input  logic              pop_i
);
  localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNTW = $clog2(DEPTH + 1);
  localparam int unsigned TW   = CW + 2;

  logic [WORD_W-1:0] mem_q [DEPTH];
  logic [PW-1:0]     wptr_q, rptr_q;
  logic [CNTW-1:0]   cnt_q, inflight_q, discard_q;
  logic [AW-1:0]     waddr_q;
  logic [CW:0]       words_left_q;
  logic [CNTW:0]     used;
  logic [TW-1:0]     total, words;
  logic              flush, req_hs, push, pop;

  assign flush = start_i | abort_i;
  assign used  = {1'b0, cnt_q} + {1'b0, inflight_q};
  // no new fetch until stale words of an aborted stream have drained
  assign req_valid_o = (words_left_q != '0) && (discard_q == '0) && !flush &&
                       (used < (CNTW+1)'(DEPTH));
  assign req_addr_o  = waddr_q;
  assign req_hs      = req_valid_o & req_ready_i;
  assign push        = rsp_valid_i && (discard_q == '0) && !flush;
  assign pop         = pop_i && (cnt_q != '0);
  assign head_valid_o = (cnt_q != '0);
  assign head_o       = mem_q[rptr_q];

  assign total = TW'(start_lane_i) + TW'(count_i);
  assign words = wide_i ? ((total + TW'(1)) >> 1) : ((total + TW'(3)) >> 2);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q       <= '0;
      rptr_q       <= '0;
      cnt_q        <= '0;
      inflight_q   <= '0;
      discard_q    <= '0;
      waddr_q      <= '0;
      words_left_q <= '0;
    end else if (flush) begin
      wptr_q     <= '0;
      rptr_q     <= '0;
      cnt_q      <= '0;
      inflight_q <= inflight_q - CNTW'(rsp_valid_i);
      discard_q  <= inflight_q - CNTW'(rsp_valid_i);
      if (start_i && !abort_i) begin
        waddr_q      <= {word_ptr_i, 3'b000};
        words_left_q <= indirect_i ? words[CW:0] : '0;
      end else begin
        words_left_q <= '0;
      end
    end else begin
      inflight_q <= inflight_q + CNTW'(req_hs) - CNTW'(rsp_valid_i);
      if (rsp_valid_i && discard_q != '0) discard_q <= discard_q - 1'b1;
      if (req_hs) begin
        waddr_q      <= waddr_q + AW'(WORD_BYTES);
        words_left_q <= words_left_q - 1'b1;
      end
      if (push) wptr_q <= (wptr_q == PW'(DEPTH-1)) ? '0 : wptr_q + 1'b1;
      if (pop)  rptr_q <= (rptr_q == PW'(DEPTH-1)) ? '0 : rptr_q + 1'b1;
      cnt_q <= cnt_q + CNTW'(push) - CNTW'(pop);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push) mem_q[wptr_q] <= rsp_data_i;
  end

  AST_FIFO_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push |-> (cnt_q < CNTW'(DEPTH)) || pop); // R10
  AST_RSP_EXPECTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_i |-> inflight_q != '0); // R9
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && !req_ready_i |=> (req_valid_o || start_i || abort_i) && $stable(req_addr_o)); // R10
endmodule

// File: rtl/isag_unpack.sv
module isag_unpack import isag_pkg::*; (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              wide_i,
  input  logic [1:0]        start_lane_i,
  input  logic              head_valid_i,
  input  logic [WORD_W-1:0] head_i,
  input  logic              take_i,
  input  logic              last_i,
  output logic [31:0]       idx_o,
  output logic              pop_o
);
  logic [1:0]  lane_q, max_lane;
  logic [15:0] h16 [LANES16];

  assign max_lane = wide_i ? 2'd1 : 2'(LANES16 - 1);
  // surplus lanes are dropped by popping on the last index
  assign pop_o = take_i && ((lane_q == max_lane) || last_i);

  for (genvar g = 0; g < LANES16; g++) begin : g_lane16
    assign h16[g] = head_i[16*g +: 16];
  end

  always_comb begin
    if (wide_i) idx_o = lane_q[0] ? head_i[63:32] : head_i[31:0];
    else        idx_o = {16'h0, h16[lane_q]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      lane_q <= '0;
    else if (start_i) lane_q <= start_lane_i;
    else if (take_i)  lane_q <= pop_o ? 2'd0 : lane_q + 2'd1;
  end

  AST_LANE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |-> lane_q <= max_lane); // R3
  AST_POP_NEEDS_HEAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_o |-> head_valid_i); // R7
endmodule

// File: rtl/idx_stream_agen.sv
module idx_stream_agen import isag_pkg::*; #(
  parameter int unsigned AW          = 32,
  parameter int unsigned CW          = 16,
  parameter int unsigned SW          = 3,
  parameter int unsigned FETCH_DEPTH = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [2:0]        cfg_addr_i,
  input  logic [AW-1:0]     cfg_wdata_i,
  output logic              idx_req_valid_o,
  input  logic              idx_req_ready_i,
  output logic [AW-1:0]     idx_req_addr_o,
  input  logic              idx_rsp_valid_i,
  input  logic [WORD_W-1:0] idx_rsp_data_i,
  output logic              addr_valid_o,
  input  logic              addr_ready_i,
  output logic [AW-1:0]     addr_o,
  output logic              done_o
);
  localparam int unsigned SHW = SW + 1;

  logic [AW-1:0]     base, stride, aff_q, off;
  logic [AW-1:1]     iptr;
  logic [CW-1:0]     count, remain_q;
  logic [SW-1:0]     shift;
  logic [SHW-1:0]    sh_amt;
  logic [1:0]        start_lane;
  logic              indirect, wide, start, hs, take, pop, head_valid;
  logic [WORD_W-1:0] head;
  logic [31:0]       idx;
  state_e            state_q;

  isag_cfg_regs #(.AW(AW), .CW(CW), .SW(SW)) u_cfg (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .addr_i(cfg_addr_i), .wdata_i(cfg_wdata_i),
    .base_o(base), .stride_o(stride), .iptr_o(iptr), .count_o(count),
    .indirect_o(indirect), .wide_o(wide), .shift_o(shift), .start_o(start)
  );

  assign start_lane = wide ? {1'b0, iptr[2]} : iptr[2:1];

  isag_idx_fetch #(.AW(AW), .CW(CW), .DEPTH(FETCH_DEPTH)) u_fetch (
    .clk_i, .rst_ni,
    .start_i(start), .abort_i(cfg_we_i),
    .indirect_i(indirect), .wide_i(wide), .start_lane_i(start_lane),
    .word_ptr_i(iptr[AW-1:3]), .count_i(count),
    .req_valid_o(idx_req_valid_o), .req_ready_i(idx_req_ready_i), .req_addr_o(idx_req_addr_o),
    .rsp_valid_i(idx_rsp_valid_i), .rsp_data_i(idx_rsp_data_i),
    .head_valid_o(head_valid), .head_o(head), .pop_i(pop)
  );

  isag_unpack u_unpack (
    .clk_i, .rst_ni,
    .start_i(start), .wide_i(wide), .start_lane_i(start_lane),
    .head_valid_i(head_valid), .head_i(head),
    .take_i(take), .last_i(remain_q == CW'(1)),
    .idx_o(idx), .pop_o(pop)
  );

  assign sh_amt = SHW'(shift) + SHW'(3);
  assign off    = AW'(idx) << sh_amt;

  assign addr_valid_o = (state_q == ST_RUN) && !cfg_we_i && (!indirect || head_valid);
  assign addr_o       = indirect ? base + off : aff_q;
  assign hs           = addr_valid_o & addr_ready_i;
  assign take         = hs & indirect;
  assign done_o       = (state_q == ST_DONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      remain_q <= '0;
      aff_q    <= '0;
    end else if (cfg_we_i) begin
      state_q <= ST_IDLE;
    end else if (start) begin
      state_q  <= (count == '0) ? ST_DONE : ST_RUN;
      remain_q <= count;
      aff_q    <= base;
    end else if (hs) begin
      remain_q <= remain_q - 1'b1;
      aff_q    <= aff_q + stride;
      if (remain_q == CW'(1)) state_q <= ST_DONE;
    end
  end

  AST_RUN_HAS_WORK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_RUN |-> remain_q != '0); // R1
  AST_ADDR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_valid_o && !addr_ready_i && !cfg_we_i |=> cfg_we_i || (addr_valid_o && $stable(addr_o))); // R7
  AST_DONE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !addr_valid_o); // R8
  AST_DONE_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(addr_valid_o && addr_ready_i) || $past(start)); // R8
  AST_AFFINE_NO_FETCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_RUN && !indirect |-> !idx_req_valid_o); // R1
endmodule

// File: tb/idx_stream_agen_test.sv
module idx_stream_agen_test;
  localparam int AW = 32;

  logic          clk_i = 1'b0, rst_ni = 1'b0;
  logic          cfg_we_i = 1'b0;
  logic [2:0]    cfg_addr_i = '0;
  logic [AW-1:0] cfg_wdata_i = '0;
  logic          idx_req_valid_o, idx_req_ready_i = 1'b1;
  logic [AW-1:0] idx_req_addr_o;
  logic          idx_rsp_valid_i;
  logic [63:0]   idx_rsp_data_i;
  logic          addr_valid_o, addr_ready_i = 1'b1, done_o;
  logic [AW-1:0] addr_o;

  idx_stream_agen uut (.*);

  always #10 clk_i = ~clk_i;

  int n_chk = 0, n_bad = 0, cyc = 0;
  int lat = 1;
  int rdy_mode = 0;  // 0 ready, 1 pseudo-random
  logic [63:0] mem [64];
  logic        pv [12];
  logic [63:0] pd [12];
  logic [AW-1:0] got[$], reqs[$];
  int            got_cyc[$];

  assign idx_rsp_valid_i = pv[lat-1];
  assign idx_rsp_data_i  = pd[lat-1];

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    pv[0] <= idx_req_valid_o && idx_req_ready_i;
    pd[0] <= mem[idx_req_addr_o[8:3]];
    for (int i = 1; i < 12; i++) begin
      pv[i] <= pv[i-1];
      pd[i] <= pd[i-1];
    end
  end

  always @(negedge clk_i) begin
    if (addr_valid_o && addr_ready_i) begin
      got.push_back(addr_o);
      got_cyc.push_back(cyc);
    end
    if (idx_req_valid_o && idx_req_ready_i) reqs.push_back(idx_req_addr_o);
  end

  initial begin
    logic [7:0] lfsr = 8'h5a;
    forever begin
      @(posedge clk_i); #1;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      if (rdy_mode == 1) begin
        addr_ready_i    = lfsr[0] & lfsr[2];
        idx_req_ready_i = lfsr[1] | lfsr[6];
      end else begin
        addr_ready_i    = 1'b1;
        idx_req_ready_i = 1'b1;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [2:0] a, input logic [AW-1:0] d);
    @(posedge clk_i); #1;
    cfg_we_i = 1'b1; cfg_addr_i = a; cfg_wdata_i = d;
    @(posedge clk_i); #1;
    cfg_we_i = 1'b0;
  endtask

  task automatic launch(input logic [AW-1:0] base, stride, iptr, count, ctrl);
    cfg_write(3'd0, base);
    cfg_write(3'd1, stride);
    cfg_write(3'd2, iptr);
    cfg_write(3'd3, count);
    got.delete(); got_cyc.delete(); reqs.delete();
    cfg_write(3'd4, ctrl);
  endtask

  task automatic wait_done(input string tag);
    int n = 0;
    while (!done_o && n < 400) begin
      @(negedge clk_i); n++;
    end
    check(done_o, tag, done_o, 1);
  endtask

  task automatic cmp_list(input string tag, input logic [AW-1:0] exp[$]);
    check(got.size() == exp.size(), {tag, " count"}, got.size(), exp.size());
    foreach (exp[i])
      if (i < got.size()) check(got[i] == exp[i], tag, got[i], exp[i]);
  endtask

  task automatic cmp_reqs(input string tag, input logic [AW-1:0] exp[$]);
    check(reqs.size() == exp.size(), {tag, " req count"}, reqs.size(), exp.size());
    foreach (exp[i])
      if (i < reqs.size()) check(reqs[i] == exp[i], tag, reqs[i], exp[i]);
  endtask

  task automatic cmp_back_to_back(input string tag);
    for (int i = 1; i < got_cyc.size(); i++)
      check(got_cyc[i] == got_cyc[i-1] + 1, tag, got_cyc[i] - got_cyc[i-1], 1);
  endtask

  task automatic t_reset();
    @(negedge clk_i);
    check(!addr_valid_o, "R11 addr_valid", addr_valid_o, 0);
    check(!done_o, "R11 done", done_o, 0);
    check(!idx_req_valid_o, "R11 idx_req_valid", idx_req_valid_o, 0);
  endtask

  task automatic t_affine();
    launch(32'h400, 32'h18, 32'h0, 5, 32'h0);
    wait_done("R1 done");
    cmp_list("R1 affine", '{32'h400, 32'h418, 32'h430, 32'h448, 32'h460});
    cmp_reqs("R1 no index fetch", '{});
    cmp_back_to_back("R6 affine rate");
  endtask

  task automatic t_ind16();
    launch(32'h8000, 32'h0, 32'h100, 7, 32'h1);
    wait_done("R2 done");
    cmp_list("R2 16b", '{32'h8010, 32'h8018, 32'h8000, 32'h8010, 32'h8018, 32'h8020, 32'h8010});
    cmp_reqs("R5 word order", '{32'h100, 32'h108});
    cmp_back_to_back("R6 16b rate");
    @(negedge clk_i);
    check(done_o && !addr_valid_o, "R8 done holds, no valid", {done_o, addr_valid_o}, 2'b10);
  endtask

  task automatic t_wide_shift();
    launch(32'h2000, 32'h0, 32'h140, 4, 32'h23);  // 32b, shift 2
    wait_done("R3 done");
    cmp_list("R3 R4 32b shift2", '{32'h20A0, 32'h2120, 32'h2020, 32'h4000});
    cmp_back_to_back("R6 32b rate");
  endtask

  task automatic t_midword();
    launch(32'h10000, 32'h0, 32'h104, 3, 32'h1);  // 16b, lane 2
    wait_done("R5 done");
    cmp_list("R5 mid-word 16b", '{32'h10000, 32'h10010, 32'h10018});
    cmp_reqs("R5 16b words", '{32'h100, 32'h108});
    launch(32'h0, 32'h0, 32'h144, 2, 32'h3);      // 32b, lane 1
    wait_done("R5 done 32b");
    cmp_list("R5 mid-word 32b", '{32'h48, 32'h8});
    cmp_reqs("R5 32b words", '{32'h140, 32'h148});
  endtask

  task automatic t_backpressure();
    rdy_mode = 1;
    launch(32'h8000, 32'h0, 32'h100, 7, 32'h1);
    wait_done("R7 done");
    rdy_mode = 0;
    cmp_list("R7 stalled 16b", '{32'h8010, 32'h8018, 32'h8000, 32'h8010, 32'h8018, 32'h8020, 32'h8010});
    cmp_reqs("R10 stalled fetch", '{32'h100, 32'h108});
  endtask

  task automatic t_zero();
    launch(32'h8000, 32'h0, 32'h100, 0, 32'h1);
    repeat (4) @(negedge clk_i);
    check(done_o, "R8 zero count done", done_o, 1);
    check(got.size() == 0, "R8 zero count no addr", got.size(), 0);
    check(reqs.size() == 0, "R8 zero count no fetch", reqs.size(), 0);
  endtask

  task automatic t_restart();
    lat = 10;
    launch(32'h8000, 32'h0, 32'h100, 7, 32'h1);
    @(posedge clk_i);  // old stream issues one word request here
    cfg_write(3'd2, 32'h144);
    cfg_write(3'd0, 32'h0);
    cfg_write(3'd3, 2);
    got.delete(); got_cyc.delete();
    cfg_write(3'd4, 32'h3);
    wait_done("R9 done");
    cmp_list("R9 restart", '{32'h48, 32'h8});
    lat = 1;
    repeat (12) @(posedge clk_i);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 64'hdead_beef_0bad_f00d;
    mem[32] = 64'h0002_0000_0003_0002;
    mem[33] = 64'h7777_0002_0004_0003;
    mem[40] = 64'h0000_0009_0000_0005;
    mem[41] = 64'h0000_0100_0000_0001;
    for (int i = 0; i < 12; i++) begin pv[i] = 1'b0; pd[i] = '0; end
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    t_reset();
    t_affine();
    t_ind16();
    t_wide_shift();
    t_midword();
    t_backpressure();
    t_zero();
    t_restart();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule